// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. It keeps an accumulator register and a five-flag status register. Each cycle with `op_valid` high, it combines the accumulator with a second operand according to a 4-bit operation code. It writes the result back to the accumulator and updates the flags that the operation defines. The carry input of every carry-consuming operation is the stored carry flag, so multi-byte arithmetic and rotates chain from one operation to the next.

The flags are sign, zero, auxiliary carry (the carry or borrow across the nibble boundary), parity (even number of ones) and carry. They are packed into a fixed flag byte. The accumulator in the upper byte and the flag byte in the lower byte together form a 16-bit program status word. Register files, instruction decode and memory operands belong to the surrounding datapath.

Top module: `alu8_psw_core`

## Requirements
- R1: While `rst_n` is low and after its release, before any operation, the accumulator is 8'h00, the flag byte is 8'h02 and `psw_o` is 16'h0002.
- R2: The flag byte holds sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bits 5 and 3 read 0 and bit 1 reads 1. `psw_o` is {accumulator, flag byte}.
- R3: Code 1 (add) and code 2 (add with carry) write acc + b (+ stored carry for code 2). Carry is set on a carry out of bit 7. Auxiliary carry is set on a carry out of bit 3.
- R4: Code 3 (subtract) and code 4 (subtract with borrow) write acc - b (- stored carry for code 4). Carry is set when a borrow out of bit 7 occurs. Auxiliary carry is set on a borrow out of the low nibble.
- R5: Codes 5, 6 and 7 write the bitwise AND, OR and XOR of acc and b, and clear both carry and auxiliary carry.
- R6: Code 8 (compare) sets every flag exactly as code 3 would, and leaves the accumulator unchanged.
- R7: Code 9 writes acc + 1 and code 10 writes acc - 1. Both ignore `opnd_b` and update the auxiliary carry as a nibble carry or borrow. The carry flag is left unchanged.
- R8: Code 11 rotates left through carry. The new accumulator is {acc[6:0], carry}, the new carry is the old acc[7], and the sign, zero, parity and auxiliary carry flags are unchanged.
- R9: After codes 1 to 7, 9 and 10, sign equals result bit 7, zero is set only when the result is 0, and parity is set when the result has an even number of ones. For code 8 these flags are taken from the difference.
- R10: Code 0 (move) loads `opnd_b` into the accumulator and leaves all flags unchanged. Codes 12 to 15, and any cycle with `op_valid` low, change neither accumulator nor flags.
- R11: Results appear on the outputs on the clock edge that samples the operation. Back-to-back operations each use the accumulator and carry left by the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation code (see R3 to R10) |
| opnd_b | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator register |
| flag_o | output | 8 | Packed flag byte |
| psw_o | output | 16 | Program status word {accumulator, flag byte} |

## Verification
In a single cycle the block both consumes the stored carry, as the carry input of add-with-carry, subtract-with-borrow and the rotate, and overwrites that same flag with the operation's new carry. The bench provokes this collision by issuing carry-chained operations on consecutive cycles, both in directed sequences and in a long pseudo-random stream. A reference model tracks accumulator and flags from the requirements. It judges every cycle's program status word, so that a carry read one cycle late or from the fresh value shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int CODE_W = 4;
    localparam int PSW_W  = 2 * DATA_W;

    // bit positions inside the packed flag byte
    localparam int POS_S  = 7;
    localparam int POS_Z  = 6;
    localparam int POS_AC = 4;
    localparam int POS_P  = 2;
    localparam int POS_CY = 0;
    localparam int POS_ONE = 1;

    typedef enum logic [CODE_W-1:0] {
        OP_MOVE = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SUB  = 4'd3,
        OP_SBB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CMP  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_RAL  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        flags_t            flg;
    } core_state_t;

    function automatic logic [DATA_W-1:0] pack_flags(input flags_t f);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[POS_S]   = f.s;
        v[POS_Z]   = f.z;
        v[POS_AC]  = f.ac;
        v[POS_P]   = f.p;
        v[POS_CY]  = f.cy;
        v[POS_ONE] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         half_co_o,
    output logic         full_co_o
);
    localparam int H  = W / 2;
    localparam int HW = W - H;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [H:0]   lo_sum;
    logic [HW:0]  hi_sum;

    // subtraction as a + ~b + ~borrow; carries come out inverted as borrows
    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = cin_i ^ sub_i;
        lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        hi_sum = {1'b0, a_i[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{HW{1'b0}}, lo_sum[H]};
        sum_o     = {hi_sum[HW-1:0], lo_sum[H-1:0]};
        half_co_o = lo_sum[H];
        full_co_o = hi_sum[HW];
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/alu8_resflags.sv
module alu8_resflags #(
    parameter int W = 8
) (
    input  logic [W-1:0] y_i,
    output logic         s_o,
    output logic         z_o,
    output logic         p_o
);
    always_comb begin
        s_o = y_i[W-1];
        z_o = (y_i == '0);
        p_o = ~(^y_i);
    end
endmodule

// File: rtl/alu8_psw_core.sv
module alu8_psw_core
    import alu8_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic [DW-1:0]     opnd_b,
    output logic [DW-1:0]     acc_o,
    output logic [DW-1:0]     flag_o,
    output logic [2*DW-1:0]   psw_o
);
    core_state_t st_q, st_d;
    alu_op_e     op;

    logic [DW-1:0] as_b, as_sum, lg_y, sel_y;
    logic          as_cin, as_sub, as_hc, as_fc;
    logic          r_s, r_z, r_p;
    logic_sel_e    lg_sel;

    assign op = alu_op_e'(op_code);

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = st_q.flg.cy;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin as_sub = 1'b1; as_cin = st_q.flg.cy; end
            OP_INC: begin as_b = '0; as_cin = 1'b1; end
            OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            default: ;
        endcase
        unique case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .a_i(st_q.acc), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .half_co_o(as_hc), .full_co_o(as_fc)
    );

    alu8_bitwise #(.W(DW)) u_bitwise (
        .a_i(st_q.acc), .b_i(opnd_b), .sel_i(lg_sel), .y_o(lg_y)
    );

    assign sel_y = (op == OP_AND || op == OP_OR || op == OP_XOR) ? lg_y : as_sum;

    alu8_resflags #(.W(DW)) u_resflags (
        .y_i(sel_y), .s_o(r_s), .z_o(r_z), .p_o(r_p)
    );

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op)
                OP_MOVE: st_d.acc = opnd_b;
                OP_ADD, OP_ADC: begin
                    st_d.acc    = as_sum;
                    st_d.flg    = '{s: r_s, z: r_z, ac: as_hc, p: r_p, cy: as_fc};
                end
                OP_SUB, OP_SBB: begin
                    st_d.acc    = as_sum;
                    st_d.flg    = '{s: r_s, z: r_z, ac: ~as_hc, p: r_p, cy: ~as_fc};
                end
                OP_CMP:
                    st_d.flg    = '{s: r_s, z: r_z, ac: ~as_hc, p: r_p, cy: ~as_fc};
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.acc    = lg_y;
                    st_d.flg    = '{s: r_s, z: r_z, ac: 1'b0, p: r_p, cy: 1'b0};
                end
                OP_INC: begin
                    st_d.acc    = as_sum;
                    st_d.flg    = '{s: r_s, z: r_z, ac: as_hc, p: r_p, cy: st_q.flg.cy};
                end
                OP_DEC: begin
                    st_d.acc    = as_sum;
                    st_d.flg    = '{s: r_s, z: r_z, ac: ~as_hc, p: r_p, cy: st_q.flg.cy};
                end
                OP_RAL: begin
                    st_d.acc    = {st_q.acc[DW-2:0], st_q.flg.cy};
                    st_d.flg.cy = st_q.acc[DW-1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign flag_o = pack_flags(st_q.flg);
    assign psw_o  = {acc_o, flag_o};

    // ---------------- assertions ----------------
    logic op_writes_flags;
    assign op_writes_flags = op_valid && (op_code >= 4'd1) && (op_code <= 4'd10) && (op_code != 4'd8);

    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o[5] == 1'b0 && flag_o[3] == 1'b0 && flag_o[1] == 1'b1);

    assert_logic_clears_cy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd5 && op_code <= 4'd7) |=> (flag_o[0] == 1'b0 && flag_o[4] == 1'b0));

    assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> $stable(acc_o));

    assert_incdec_keeps_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd9 || op_code == 4'd10)) |=> $stable(flag_o[0]));

    assert_ral_moves_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd11) |=> (flag_o[0] == $past(acc_o[7]) && acc_o[0] == $past(flag_o[0])));

    assert_result_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_writes_flags |=> (flag_o[7] == acc_o[7] && flag_o[6] == (acc_o == '0) && flag_o[2] == ~(^acc_o)));

    assert_move_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=> ($stable(flag_o) && acc_o == $past(opnd_b)));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code >= 4'd12) |=> $stable(psw_o));
endmodule

// File: tb/sim_alu8_psw_core.sv
`timescale 1ns/1ps
module sim_alu8_psw_core;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [7:0]  opnd_b = 8'd0;
    logic [7:0]  acc_o, flag_o;
    logic [15:0] psw_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // reference model state
    logic [7:0] m_acc = 8'h00;
    logic m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #(HALF) clk = ~clk;

    alu8_psw_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_b(opnd_b), .acc_o(acc_o), .flag_o(flag_o), .psw_o(psw_o)
    );

    function automatic logic [15:0] model_psw();
        return {m_acc, m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
    endfunction

    task automatic set_szp(input logic [7:0] r);
        m_s = r[7];
        m_z = (r == 8'h00);
        m_p = ~(^r);
    endtask

    task automatic model_step(input logic v, input logic [3:0] c, input logic [7:0] b);
        int a, bi, k, r;
        logic [7:0] res;
        logic nc;
        a  = int'(m_acc);
        bi = int'(b);
        if (!v) return;
        case (c)
            4'd0: m_acc = b;
            4'd1, 4'd2: begin
                k = (c == 4'd2) ? int'(m_cy) : 0;
                r = a + bi + k;
                m_ac = ((a % 16) + (bi % 16) + k) > 15;
                m_cy = r > 255;
                m_acc = 8'(r);
                set_szp(m_acc);
            end
            4'd3, 4'd4, 4'd8: begin
                k = (c == 4'd4) ? int'(m_cy) : 0;
                r = a - bi - k;
                m_ac = (a % 16) < ((bi % 16) + k);
                m_cy = r < 0;
                res = 8'(r);
                if (c != 4'd8) m_acc = res;
                set_szp(res);
            end
            4'd5, 4'd6, 4'd7: begin
                res = (c == 4'd5) ? (m_acc & b) : (c == 4'd6) ? (m_acc | b) : (m_acc ^ b);
                m_cy = 1'b0;
                m_ac = 1'b0;
                m_acc = res;
                set_szp(res);
            end
            4'd9: begin
                m_ac = (a % 16) == 15;
                m_acc = 8'(a + 1);
                set_szp(m_acc);
            end
            4'd10: begin
                m_ac = (a % 16) == 0;
                m_acc = 8'(a - 1);
                set_szp(m_acc);
            end
            4'd11: begin
                nc = m_acc[7];
                m_acc = {m_acc[6:0], m_cy};
                m_cy = nc;
            end
            default: ;
        endcase
    endtask

    // driver: drive at the falling edge, push the expected word
    task automatic issue(input logic v, input logic [3:0] c, input logic [7:0] b, input string tag);
        @(negedge clk);
        op_valid = v;
        op_code  = c;
        opnd_b   = b;
        model_step(v, c, b);
        exp_q.push_back(model_psw());
        tag_q.push_back(tag);
    endtask

    // monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        logic [15:0] e;
        string t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (psw_o !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, psw_o, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (psw_o !== 16'h0002 || acc_o !== 8'h00 || flag_o !== 8'h02) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=%h", psw_o, 16'h0002);
        end
        @(negedge clk);
        rst_n = 1'b1;

        issue(1, 4'd0, 8'h3A, "R10 move");
        issue(1, 4'd1, 8'hC6, "R3 add carry+ac zero");
        checks++;
        #3;
        if (flag_o !== 8'h57) begin
            errors++;
            $display("FAIL R2 layout actual=%h expected=%h", flag_o, 8'h57);
        end
        issue(1, 4'd2, 8'h01, "R3 adc uses carry");
        issue(1, 4'd1, 8'h7F, "R9 add sign");
        issue(1, 4'd3, 8'h90, "R4 sub borrow");
        issue(1, 4'd4, 8'h01, "R4 sbb uses borrow");
        issue(1, 4'd4, 8'h00, "R11 sbb chained");
        issue(1, 4'd0, 8'h55, "R10 move keeps flags");
        issue(1, 4'd8, 8'h55, "R6 cmp equal");
        issue(1, 4'd8, 8'h56, "R6 cmp less");
        issue(1, 4'd5, 8'h0F, "R5 and");
        issue(1, 4'd1, 8'hFF, "R3 set carry");
        issue(1, 4'd6, 8'hA0, "R5 or clears cy");
        issue(1, 4'd7, 8'hA5, "R5 xor");
        issue(1, 4'd0, 8'hFF, "R10 move ff");
        issue(1, 4'd1, 8'h01, "R3 wrap");
        issue(1, 4'd0, 8'hFF, "R10 move");
        issue(1, 4'd9, 8'h33, "R7 inc wrap keeps cy");
        issue(1, 4'd10, 8'h77, "R7 dec from zero");
        issue(1, 4'd11, 8'h00, "R8 ral");
        issue(1, 4'd11, 8'h00, "R8 ral chained");
        issue(1, 4'd12, 8'h12, "R10 unused code");
        issue(1, 4'd15, 8'h34, "R10 unused code");
        issue(0, 4'd1, 8'h56, "R10 valid low");

        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[5] | lf[6] | lf[7], lf[3:0], lf[15:8] ^ lf[7:0], "R11 random stream");
        end
        issue(0, 4'd0, 8'h00, "R10 idle");
        repeat (3) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule